// File: doc/BRIEF.md
# Pipelined Burst SRAM Core

This block is a synthesizable behavioural model of a synchronous static RAM with a registered read path and a four-beat burst. Every control, address and write-data input is sampled on the rising clock edge. Each cycle is sorted into one of four kinds: a new burst, a continued burst (next address), a suspended burst (same address, a wait state), or a deselect. Writes go to any mix of the four byte lanes in the same cycle they are presented. Read data leaves through an output register one clock after the address cycle.

Two address strobes start bursts, and they follow different rules. The processor strobe is qualified by the primary enable and always opens with a read. The controller strobe opens with a read or a write, depending on the write inputs. The two secondary enables are looked at only when a strobe is low. A sleep input puts the array into a retention state after two sampled clocks. The block leaves that state only after a short wake gap. Any strobe given while the block is locked is dropped and flagged. Output drive is shown by a valid flag gated by an active-low output enable, and undriven data reads as zero. The default depth is 1024 words (`AW` = 10). A full-size instance sets `AW` to 15 for 32768 words.

Top module: `pbsram_core`

## Requirements
- R1: A read cycle sampled at edge N makes its word appear on `rdata`, with `rvalid` high, after edge N+1, as long as `oe_n` is low.
- R2: With `gwe_n` high and `bwe_n` low, byte lane i (bits 8i+7:8i, with i from 0 to 3) is written only when `be_n[i]` is low. With `bwe_n` high, `be_n` has no effect, and a cycle without `gwe_n` low is a read.
- R3: A low `gwe_n` writes all four lanes, whatever the values of `bwe_n` and `be_n`.
- R4: A low `ps_n` with `ce_n` low begins a burst with a read, even when the write inputs are asserted. A write on that burst happens only in a later cycle in which both strobes are high.
- R5: While `ce_n` is high, `ps_n` is ignored and the cycle acts as a no-strobe cycle. On no-strobe cycles, `ce2` and `ce3_n` have no effect.
- R6: A strobe cycle with `ce_n` high, `ce2` low or `ce3_n` high is a deselect. It ends the burst, `rvalid` is low after the next edge, and later no-strobe cycles do nothing until a new burst begins.
- R7: A no-strobe cycle with `adv_n` low moves to the next beat k (k counts modulo 4 from 0 at the start). With `seq_lin`=1 the two low address bits are base+k mod 4. With `seq_lin`=0 they are base XOR k. The upper bits stay at their base values.
- R8: A no-strobe cycle with `adv_n` high repeats the current beat address, for reads and for writes.
- R9: `rvalid` is high only when the registered data-valid flag is set and `oe_n` is low. `oe_n` acts without a clock, and `rdata` is zero whenever `rvalid` is low.
- R10: A write at edge N clears the data-valid flag at that edge, so `rvalid` is low after edge N.
- R11: Once `sleep` has been sampled high at two edges in a row, the block is locked. While locked, nothing is read or written, the valid flag is cleared, and the array keeps its contents. The lock lasts through the first edge at which `sleep` is sampled low and through one more edge.
- R12: A strobe (`ps_n` or `cs_n` low) sampled while the block is locked is ignored. It raises `err` for the single cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | AW | Word address used when a burst begins |
| ps_n | input | 1 | Processor strobe, active low, always opens with a read |
| cs_n | input | 1 | Controller strobe, active low, opens with a read or a write |
| adv_n | input | 1 | Active-low advance: low moves to the next beat, high holds the current beat |
| ce_n | input | 1 | Primary enable, active low, also qualifies `ps_n` |
| ce2 | input | 1 | Secondary enable, active high, examined on strobe cycles only |
| ce3_n | input | 1 | Secondary enable, active low, examined on strobe cycles only |
| gwe_n | input | 1 | Active-low write of all lanes |
| bwe_n | input | 1 | Active-low qualifier for the per-lane enables |
| be_n | input | DW/8 | Active-low per-lane write enables |
| wdata | input | DW | Write data |
| oe_n | input | 1 | Active-low output enable, acts without a clock |
| sleep | input | 1 | Retention request |
| seq_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| rdata | output | DW | Read data, zero when not driven |
| rvalid | output | 1 | Read data is being driven |
| err | output | 1 | A strobe was dropped during lock |

## Verification
A wrong beat counter or a wrong captured base shows up as a wrong word on `rdata` one clock after the bad address cycle. A lost write shows up the first time that word is read back. A valid flag that is stuck or misrouted shows up at once on `rvalid`, either during a write, after a deselect, or while the block is locked. A lock counter off by one changes whether a strobe near the sleep edges is served or flagged on `err`, and that is visible in the next cycle.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  localparam int unsigned LANE_W  = 8;
  localparam int unsigned BURST_W = 2;
endpackage

// File: rtl/pbs_cycle_decode.sv
module pbs_cycle_decode
  import pbsram_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             ps_n,
  input  logic             cs_n,
  input  logic             adv_n,
  input  logic             ce_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             gwe_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] be_n,
  input  logic             active,
  input  logic             locked,
  output op_e              op,
  output logic             start,
  output logic             deselect,
  output logic             step,
  output logic             strobe_seen,
  output logic [LANES-1:0] lane_we
);
  logic [LANES-1:0] lane_mask;
  logic             wr_req;
  logic             proc_hit;
  logic             any_hit;

  always_comb begin
    lane_mask   = !gwe_n ? '1 : (!bwe_n ? ~be_n : '0);
    wr_req      = |lane_mask;
    proc_hit    = !ps_n && !ce_n;
    any_hit     = proc_hit || !cs_n;
    strobe_seen = !ps_n || !cs_n;
    op          = OP_NONE;
    start       = 1'b0;
    deselect    = 1'b0;
    step        = 1'b0;
    if (!locked) begin
      if (any_hit) begin
        if (ce_n || !ce2 || ce3_n) begin
          deselect = 1'b1;
        end else begin
          start = 1'b1;
          op    = (!proc_hit && wr_req) ? OP_WRITE : OP_READ;
        end
      end else if (active) begin
        step = !adv_n;
        op   = wr_req ? OP_WRITE : OP_READ;
      end
    end
    lane_we = (op == OP_WRITE) ? lane_mask : '0;
  end
endmodule

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq
  import pbsram_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lin,
  input  logic          start,
  input  logic          deselect,
  input  logic          step,
  input  logic [AW-1:0] addr_in,
  output logic          active,
  output logic [AW-1:0] cur_addr
);
  localparam int unsigned CW = BURST_W;

  logic [AW-1:0] base_q, base_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          act_q, act_n;
  logic [CW-1:0] off;
  logic          upd;

  always_comb begin
    upd    = start || deselect || step;
    cnt_n  = start ? '0 : (step ? cnt_q + CW'(1) : cnt_q);
    base_n = start ? addr_in : base_q;
    act_n  = start ? 1'b1 : (deselect ? 1'b0 : act_q);
    off    = lin ? (base_q[CW-1:0] + cnt_n) : (base_q[CW-1:0] ^ cnt_n);
    cur_addr = start ? addr_in : {base_q[AW-1:CW], off};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (upd) begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
      act_q  <= act_n;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/pbs_sleep_ctl.sv
module pbs_sleep_ctl #(
  parameter int unsigned ENTER = 2,
  parameter int unsigned REC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic locked
);
  localparam int unsigned SW = $clog2(ENTER + 1);
  localparam int unsigned RW = (REC > 1) ? $clog2(REC + 1) : 1;

  logic [SW-1:0] slp_q, slp_n;
  logic [RW-1:0] rec_q, rec_n;
  logic          pd;
  logic          en;

  always_comb begin
    pd    = (slp_q == SW'(ENTER));
    slp_n = sleep ? (pd ? slp_q : slp_q + SW'(1)) : '0;
    rec_n = (!sleep && pd) ? RW'(REC - 1)
          : ((rec_q != '0) ? rec_q - RW'(1) : rec_q);
    en    = sleep || (slp_q != '0) || (rec_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_q <= '0;
      rec_q <= '0;
    end else if (en) begin
      slp_q <= slp_n;
      rec_q <= rec_n;
    end
  end

  assign locked = pd || (rec_q != '0);
endmodule

// File: rtl/pbs_array.sv
module pbs_array
  import pbsram_pkg::*;
#(
  parameter int unsigned AW    = 10,
  parameter int unsigned LANES = 4
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    re,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      if (re)    q <= mem[raddr];
    end
    assign rdata[g*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/pbsram_core.sv
module pbsram_core
  import pbsram_pkg::*;
#(
  parameter int unsigned AW          = 10,
  parameter int unsigned DW          = 32,
  parameter int unsigned SLEEP_ENTER = 2,
  parameter int unsigned WAKE_GAP    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic               ps_n,
  input  logic               cs_n,
  input  logic               adv_n,
  input  logic               ce_n,
  input  logic               ce2,
  input  logic               ce3_n,
  input  logic               gwe_n,
  input  logic               bwe_n,
  input  logic [DW/8-1:0]    be_n,
  input  logic [DW-1:0]      wdata,
  input  logic               oe_n,
  input  logic               sleep,
  input  logic               seq_lin,
  output logic [DW-1:0]      rdata,
  output logic               rvalid,
  output logic               err
);
  localparam int unsigned LANES = DW / LANE_W;

  logic [1:0]       rs_q;
  logic             srst_n;
  op_e              op;
  logic             start, deselect, step, strobe_seen;
  logic [LANES-1:0] lane_we;
  logic             active, locked;
  logic [AW-1:0]    cur_addr;
  logic [DW-1:0]    arr_q;
  logic             rd_q, rd_n;
  logic             dv_q, dv_n;
  logic             err_q, err_n;
  logic [AW-1:0]    raddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  pbs_cycle_decode #(.LANES(LANES)) u_dec (
    .ps_n(ps_n), .cs_n(cs_n), .adv_n(adv_n), .ce_n(ce_n), .ce2(ce2),
    .ce3_n(ce3_n), .gwe_n(gwe_n), .bwe_n(bwe_n), .be_n(be_n),
    .active(active), .locked(locked), .op(op), .start(start),
    .deselect(deselect), .step(step), .strobe_seen(strobe_seen),
    .lane_we(lane_we)
  );

  pbs_burst_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(srst_n), .lin(seq_lin), .start(start),
    .deselect(deselect), .step(step), .addr_in(addr),
    .active(active), .cur_addr(cur_addr)
  );

  pbs_sleep_ctl #(.ENTER(SLEEP_ENTER), .REC(WAKE_GAP)) u_slp (
    .clk(clk), .rst_n(srst_n), .sleep(sleep), .locked(locked)
  );

  pbs_array #(.AW(AW), .LANES(LANES)) u_arr (
    .clk(clk), .we(lane_we), .waddr(cur_addr), .wdata(wdata),
    .re(rd_q), .raddr(raddr_q), .rdata(arr_q)
  );

  always_comb begin
    rd_n  = (op == OP_READ);
    dv_n  = ((op == OP_WRITE) || locked) ? 1'b0 : rd_q;
    err_n = locked && strobe_seen;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_q    <= 1'b0;
      dv_q    <= 1'b0;
      err_q   <= 1'b0;
      raddr_q <= '0;
    end else begin
      rd_q  <= rd_n;
      dv_q  <= dv_n;
      err_q <= err_n;
      if (rd_n) raddr_q <= cur_addr;
    end
  end

  assign rvalid = dv_q && !oe_n;
  assign rdata  = rvalid ? arr_q : '0;
  assign err    = err_q;
endmodule

// File: rtl/pbsram_chk.sv
module pbsram_chk
  import pbsram_pkg::*;
(
  input logic               clk,
  input logic               srst_n,
  input logic               ps_n,
  input logic               cs_n,
  input logic               adv_n,
  input logic               locked,
  input op_e                op,
  input logic               start,
  input logic               deselect,
  input logic               step,
  input logic               rd_q,
  input logic               dv_q,
  input logic               err_q,
  input logic [BURST_W-1:0] cnt_q
);
  // R10
  write_clears_valid_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (op == OP_WRITE) |=> !dv_q);

  // R6
  deselect_blanks_chk: assert property (@(posedge clk) disable iff (!srst_n)
    deselect |-> ##2 !dv_q);

  // R1
  valid_needs_read_chk: assert property (@(posedge clk) disable iff (!srst_n)
    dv_q |-> $past(rd_q));

  // R12
  err_from_strobe_chk: assert property (@(posedge clk) disable iff (!srst_n)
    err_q |-> $past(!ps_n || !cs_n));

  // R8
  suspend_holds_count_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!locked && ps_n && cs_n && adv_n) |=> $stable(cnt_q));

  // R7
  begin_clears_count_chk: assert property (@(posedge clk) disable iff (!srst_n)
    start |=> (cnt_q == '0));

  // R11
  sleep_blanks_chk: assert property (@(posedge clk) disable iff (!srst_n)
    locked |=> !dv_q);

  // R5
  cycle_kind_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({start, deselect, step}));
endmodule

bind pbsram_core pbsram_chk u_chk (
  .clk(clk), .srst_n(srst_n), .ps_n(ps_n), .cs_n(cs_n), .adv_n(adv_n),
  .locked(locked), .op(op), .start(start), .deselect(deselect),
  .step(step), .rd_q(rd_q), .dv_q(dv_q), .err_q(err_q),
  .cnt_q(u_seq.cnt_q)
);

// File: tb/sim_pbsram_core.sv
module sim_pbsram_core;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ps_n, cs_n, adv_n, ce_n, ce2, ce3_n, gwe_n, bwe_n;
  logic [3:0]    be_n;
  logic [31:0]   wdata;
  logic          oe_n, sleep, seq_lin;
  logic [31:0]   rdata;
  logic          rvalid, err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string ph = "R9";

  // reference state
  logic [31:0] m_mem [int];
  bit          m_act, m_rdp, m_dv, m_err;
  int          m_base, m_k, m_raddr, m_slp, m_rec;
  logic [31:0] m_rdata;

  always #5 clk = ~clk;

  pbsram_core u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ps_n(ps_n), .cs_n(cs_n),
    .adv_n(adv_n), .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n), .gwe_n(gwe_n),
    .bwe_n(bwe_n), .be_n(be_n), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
    .seq_lin(seq_lin), .rdata(rdata), .rvalid(rvalid), .err(err)
  );

  function automatic logic [31:0] pat(int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit lk, sp, pd;
    logic [3:0] msk;
    int op, a;
    logic [31:0] w;
    lk  = (m_slp == 2) || (m_rec > 0);
    sp  = !ps_n && !ce_n;
    msk = !gwe_n ? 4'hf : (!bwe_n ? ~be_n : 4'h0);
    op  = 0;
    a   = 0;
    if (!lk) begin
      if (sp || !cs_n) begin
        if (ce_n || !ce2 || ce3_n) m_act = 0;
        else begin
          m_act = 1; m_base = int'(addr); m_k = 0; a = int'(addr);
          op = sp ? 1 : ((msk != 0) ? 2 : 1);
        end
      end else if (m_act) begin
        if (!adv_n) m_k = (m_k + 1) % 4;
        a = (m_base & ~3) | (seq_lin ? ((m_base + m_k) % 4) : ((m_base & 3) ^ m_k));
        op = (msk != 0) ? 2 : 1;
      end
    end
    if (m_rdp) m_rdata = m_mem[m_raddr];
    m_dv = (op == 2 || lk) ? 0 : m_rdp;
    if (op == 2) begin
      w = m_mem.exists(a) ? m_mem[a] : 32'h0;
      for (int i = 0; i < 4; i++) if (msk[i]) w[8*i +: 8] = wdata[8*i +: 8];
      m_mem[a] = w;
    end
    m_rdp = (op == 1);
    if (op == 1) m_raddr = a;
    m_err = lk && (!ps_n || !cs_n);
    pd = (m_slp == 2);
    if (!sleep && pd) m_rec = 1;
    else if (m_rec > 0) m_rec--;
    if (sleep) begin if (!pd) m_slp++; end
    else m_slp = 0;
  endtask

  task automatic compare();
    bit ev;
    ev = m_dv && !oe_n;
    chk({ph, " rvalid"}, {31'd0, rvalid}, {31'd0, ev});
    chk({ph, " rdata"}, rdata, ev ? m_rdata : 32'h0);
    chk({ph, " err"}, {31'd0, err}, {31'd0, m_err});
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic cyc(bit p, bit c, bit adv, bit g, bit bw, logic [3:0] be,
                     int a, logic [31:0] d);
    ps_n = p; cs_n = c; adv_n = adv; gwe_n = g; bwe_n = bw; be_n = be;
    addr = AW'(a); wdata = d;
    tick();
  endtask

  task automatic idle();
    cyc(1, 1, 1, 1, 1, 4'hf, 0, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ps_n = 1; cs_n = 1; adv_n = 1; ce_n = 0; ce2 = 1; ce3_n = 0;
    gwe_n = 1; bwe_n = 1; be_n = 4'hf; wdata = 0; addr = 0; oe_n = 0;
    sleep = 0; seq_lin = 1;
    m_act = 0; m_rdp = 0; m_dv = 0; m_err = 0; m_base = 0; m_k = 0;
    m_raddr = 0; m_slp = 0; m_rec = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset rvalid", {31'd0, rvalid}, 32'd0);
    chk("R9 reset rdata", rdata, 32'd0);
    chk("R12 reset err", {31'd0, err}, 32'd0);
    rst_n = 1;
    repeat (4) idle();

    // R3: fill whole array with global-write linear bursts
    ph = "R3";
    for (int b = 0; b < DEPTH; b += 4) begin
      cyc(1, 0, 1, 0, 1, 4'hf, b, pat(b));
      for (int k = 1; k < 4; k++) cyc(1, 1, 0, 0, 1, 4'hf, 0, pat(b + k));
    end

    // R1 / R7 linear burst, R8 suspend
    ph = "R7";
    cyc(0, 1, 1, 1, 1, 4'hf, 'h10, 0);
    cyc(1, 1, 0, 1, 1, 4'hf, 0, 0); chk("R1 first beat", rdata, pat('h10));
    cyc(1, 1, 0, 1, 1, 4'hf, 0, 0); chk("R7 linear beat1", rdata, pat('h11));
    cyc(1, 1, 0, 1, 1, 4'hf, 0, 0); chk("R7 linear beat2", rdata, pat('h12));
    idle();                          chk("R7 linear beat3", rdata, pat('h13));
    idle();                          chk("R8 suspend repeat", rdata, pat('h13));

    // R7 interleaved from low bits 2
    seq_lin = 0;
    cyc(0, 1, 1, 1, 1, 4'hf, 'h22, 0);
    cyc(1, 1, 0, 1, 1, 4'hf, 0, 0); chk("R7 ilv beat0", rdata, pat('h22));
    cyc(1, 1, 0, 1, 1, 4'hf, 0, 0); chk("R7 ilv beat1", rdata, pat('h23));
    cyc(1, 1, 0, 1, 1, 4'hf, 0, 0); chk("R7 ilv beat2", rdata, pat('h20));
    idle();                          chk("R7 ilv beat3", rdata, pat('h21));
    seq_lin = 1;

    // R2 byte lanes, R3 global write overrides
    ph = "R2";
    cyc(1, 0, 1, 0, 1, 4'hf, 'h30, 32'h11223344);
    cyc(1, 0, 1, 1, 0, 4'b1010, 'h30, 32'hAABBCCDD);
    cyc(1, 0, 1, 1, 1, 4'b0000, 'h30, 32'h0);
    idle(); chk("R2 lanes 0 and 2", rdata, 32'h11BB33DD);
    cyc(1, 0, 1, 0, 0, 4'hf, 'h34, 32'h0BADCAFE);
    cyc(1, 0, 1, 1, 1, 4'hf, 'h34, 32'h0);
    idle(); chk("R3 global write", rdata, 32'h0BADCAFE);

    // R4 processor strobe reads, write follows; R10 valid killed
    ph = "R4";
    cyc(0, 1, 1, 0, 1, 4'hf, 'h31, 32'hDEADBEEF);
    cyc(1, 1, 1, 0, 1, 4'hf, 0, 32'hCAFEF00D);
    chk("R10 write kills valid", {31'd0, rvalid}, 32'd0);
    cyc(1, 0, 1, 1, 1, 4'hf, 'h31, 0);
    idle(); chk("R4 delayed write", rdata, 32'hCAFEF00D);

    // R5 ignored strobe and secondary enables
    ph = "R5";
    cyc(1, 0, 1, 1, 1, 4'hf, 'h40, 0);
    ce_n = 1; cyc(0, 1, 0, 1, 1, 4'hf, 'h77, 0); ce_n = 0;
    ce2 = 0; ce3_n = 1; cyc(1, 1, 0, 1, 1, 4'hf, 0, 0); ce2 = 1; ce3_n = 0;
    chk("R5 ps ignored", rdata, pat('h41));
    idle(); chk("R5 ce2 ce3 ignored", rdata, pat('h42));

    // R6 deselect
    ph = "R6";
    ce2 = 0; cyc(1, 0, 1, 1, 1, 4'hf, 'h50, 0); ce2 = 1;
    cyc(1, 1, 0, 1, 1, 4'hf, 0, 0); chk("R6 off after deselect", {31'd0, rvalid}, 32'd0);
    cyc(1, 1, 0, 1, 1, 4'hf, 0, 0); chk("R6 stays off", {31'd0, rvalid}, 32'd0);

    // R9 output enable gate
    ph = "R9";
    cyc(0, 1, 1, 1, 1, 4'hf, 'h44, 0);
    oe_n = 1; idle();
    chk("R9 gated rvalid", {31'd0, rvalid}, 32'd0);
    chk("R9 gated rdata", rdata, 32'd0);
    oe_n = 0; #1;
    chk("R9 enabled rvalid", {31'd0, rvalid}, 32'd1);
    chk("R9 enabled rdata", rdata, pat('h44));

    // R11 / R12 sleep
    ph = "R11";
    sleep = 1; idle(); idle();
    cyc(1, 0, 1, 0, 1, 4'hf, 'h60, 32'h0);
    chk("R12 err on locked strobe", {31'd0, err}, 32'd1);
    chk("R11 valid cleared", {31'd0, rvalid}, 32'd0);
    sleep = 0; idle();
    chk("R12 err one cycle", {31'd0, err}, 32'd0);
    idle();
    cyc(1, 0, 1, 1, 1, 4'hf, 'h60, 0);
    idle(); chk("R11 retained", rdata, pat('h60));

    // mixed random traffic checked against the reference every cycle
    ph = "R7";
    for (int n = 0; n < 3000; n++) begin
      if (n % 500 == 0) seq_lin = $urandom % 2;
      if ($urandom % 64 == 0) sleep = ~sleep;
      ce_n  = ($urandom % 8) == 0;
      ce2   = ($urandom % 8) != 0;
      ce3_n = ($urandom % 8) == 0;
      oe_n  = ($urandom % 8) == 0;
      cyc(($urandom % 4) != 0, ($urandom % 4) != 0, $urandom % 2,
          ($urandom % 8) != 0, ($urandom % 4) != 0, 4'($urandom),
          int'($urandom % DEPTH), $urandom);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule